// File: doc/BRIEF.md
# SPI Interrupt Event and Enable Registers

This block keeps the sticky interrupt flags of a serial peripheral interface controller, plus the per-flag enable register that gates them. It drives one level-sensitive interrupt request. The controller's datapath reports four conditions as one-cycle pulses: a transmit error, a busy condition (a character arrived and was dropped because no receive buffer was free), a finished transmit buffer and a finished receive buffer. The block detects a fifth condition itself. That condition is a multimaster conflict: the slave-select input is driven low from outside while the controller is configured as master.

Software sees two 8-bit registers through a simple read/write port. In the flag register, writing a 1 to a bit clears it and writing a 0 leaves it unchanged. The enable register is plain read/write storage. Each flag has a fixed bit position, counted with register bit 7 as the most significant. Three positions are unused and always read as zero. The interrupt line stays high while any flag that is set is also enabled.

Top module: `spi_evt_irq`

## Requirements
- R1: While `rst_n` is low, and right after it rises, both the flag register and the enable register read 0x00.
- R2: A one-cycle pulse sets its flag at the next clock edge, and the flag stays set. The flag positions are: bit 4 transmit error (`ev_txe`), bit 2 busy (`ev_busy`), bit 1 transmit buffer done (`ev_txb`), bit 0 receive buffer done (`ev_rxb`).
- R3: A write to the flag register (`wr_en`=1, `wr_sel`=0) clears every flag whose `wr_data` bit is 1. Flags whose `wr_data` bit is 0 are left unchanged.
- R4: If a flag is set and cleared by a write in the same cycle, the set wins and the flag reads 1 afterwards.
- R5: A write to the enable register (`wr_en`=1, `wr_sel`=1) loads `wr_data` into its implemented bits. Without such a write the register holds its value.
- R6: `irq` is high exactly when at least one flag is 1 and its enable bit is also 1. A set flag whose enable bit is 0 does not raise `irq`.
- R7: Bit 5 (multimaster conflict) sets at the next clock edge whenever `master_mode`=1 and `sel_n`=0 in a cycle. When `master_mode`=0, a low `sel_n` does not set it.
- R8: Bits 7, 6 and 3 of both registers always read 0, and writes to them have no effect.
- R9: `rd_data` shows the flag register when `rd_sel`=0 and the enable register when `rd_sel`=1. The read path is combinational in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 flags, 1 enables |
| wr_data | input | 8 | Write data |
| rd_sel | input | 1 | Read source: 0 flags, 1 enables |
| rd_data | output | 8 | Read data |
| master_mode | input | 1 | Controller is configured as master |
| sel_n | input | 1 | External slave-select, active low |
| ev_txe | input | 1 | Transmit error pulse |
| ev_busy | input | 1 | Character dropped, no buffer pulse |
| ev_txb | input | 1 | Transmit buffer done pulse |
| ev_rxb | input | 1 | Receive buffer done pulse |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets a clear and an event that land on the same bit in the same cycle. A design that gave priority to the clear would lose the event, and the mismatch appears one cycle later on the read port. It also writes 0xFF to both registers to check the unused bits: a design that stored them would read them back, or would let them raise `irq` spuriously. Slave-select is driven low in both master and slave mode, which catches a conflict detector that ignores the mode. Masked flags are set without any enable bit, to show that `irq` follows only enabled flags and stays high until the last enabled flag is cleared.

// File: rtl/spi_evt_irq.sv
module spi_evt_irq #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic         rd_sel,
  output logic [W-1:0] rd_data,
  input  logic         master_mode,
  input  logic         sel_n,
  input  logic         ev_txe,
  input  logic         ev_busy,
  input  logic         ev_txb,
  input  logic         ev_rxb,
  output logic         irq
);
  localparam int B_MME = 5;
  localparam int B_TXE = 4;
  localparam int B_BSY = 2;
  localparam int B_TXB = 1;
  localparam int B_RXB = 0;
  localparam logic [W-1:0] IMPL = W'((1 << B_MME) | (1 << B_TXE) | (1 << B_BSY)
                                    | (1 << B_TXB) | (1 << B_RXB));

  logic [W-1:0] ev_q, mask_q, ev_set, ev_clr;
  logic         mme_hit;

  assign mme_hit = master_mode & ~sel_n;

  always_comb begin
    ev_set        = '0;
    ev_set[B_MME] = mme_hit;
    ev_set[B_TXE] = ev_txe;
    ev_set[B_BSY] = ev_busy;
    ev_set[B_TXB] = ev_txb;
    ev_set[B_RXB] = ev_rxb;
  end

  assign ev_clr = (wr_en && !wr_sel) ? wr_data : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_q   <= '0;
      mask_q <= '0;
    end else begin
      ev_q <= ((ev_q & ~ev_clr) | ev_set) & IMPL;
      if (wr_en && wr_sel) mask_q <= wr_data & IMPL;
    end
  end

  assign rd_data = rd_sel ? mask_q : ev_q;
  assign irq     = |(ev_q & mask_q);
endmodule

// File: rtl/spi_evt_irq_chk.sv
module spi_evt_irq_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic         wr_sel,
  input logic [W-1:0] wr_data,
  input logic         master_mode,
  input logic         sel_n,
  input logic         ev_txe,
  input logic         ev_busy,
  input logic         ev_txb,
  input logic         ev_rxb,
  input logic [W-1:0] ev_q,
  input logic [W-1:0] mask_q,
  input logic         irq
);
  localparam logic [W-1:0] RSVD = W'(8'hC8);

  assert_reset_zero_R1: assert property (@(posedge clk)
    !rst_n |-> (ev_q == '0 && mask_q == '0));

  assert_txe_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_txe |=> ev_q[4]);

  assert_rxb_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rxb |=> ev_q[0]);

  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel && wr_data[1] && !ev_txb) |=> !ev_q[1]);

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_en && !wr_sel) && !ev_txe && !ev_busy && !ev_txb && !ev_rxb
     && !(master_mode && !sel_n)) |=> $stable(ev_q));

  assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel && wr_data[2] && ev_busy) |=> ev_q[2]);

  assert_mask_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_sel) |=> $stable(mask_q));

  assert_irq_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ev_q != '0 && mask_q != '0));

  assert_mme_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && !sel_n) |=> ev_q[5]);

  assert_reserved_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((ev_q & RSVD) == '0) && ((mask_q & RSVD) == '0));
endmodule

bind spi_evt_irq spi_evt_irq_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .master_mode(master_mode), .sel_n(sel_n), .ev_txe(ev_txe), .ev_busy(ev_busy),
  .ev_txb(ev_txb), .ev_rxb(ev_rxb), .ev_q(ev_q), .mask_q(mask_q), .irq(irq)
);

// File: tb/sim_spi_evt_irq.sv
module sim_spi_evt_irq;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] IMPL = 8'h37;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       wr_en = 0, wr_sel = 0, rd_sel = 0;
  logic [7:0] wr_data = 0;
  logic       master_mode = 0, sel_n = 1;
  logic       ev_txe = 0, ev_busy = 0, ev_txb = 0, ev_rxb = 0;
  logic [7:0] rd_data;
  logic       irq;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [7:0] m_ev = 0, m_mask = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_evt_irq u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .master_mode(master_mode), .sel_n(sel_n),
    .ev_txe(ev_txe), .ev_busy(ev_busy), .ev_txb(ev_txb), .ev_rxb(ev_rxb), .irq(irq)
  );

  task automatic chk8(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic compare(string tag);
    #1;
    chk8(tag, rd_data, rd_sel ? m_mask : m_ev);
    chk8(tag, {7'd0, irq}, {7'd0, (m_ev & m_mask) != 0});
  endtask

  task automatic idle();
    wr_en = 0; wr_sel = 0; wr_data = 0;
    ev_txe = 0; ev_busy = 0; ev_txb = 0; ev_rxb = 0; sel_n = 1;
  endtask

  task automatic step(string tag);
    logic [7:0] set, clr;
    compare(tag);
    @(posedge clk);
    set = 0;
    if (master_mode && !sel_n) set[5] = 1;
    if (ev_txe)  set[4] = 1;
    if (ev_busy) set[2] = 1;
    if (ev_txb)  set[1] = 1;
    if (ev_rxb)  set[0] = 1;
    clr = (wr_en && !wr_sel) ? wr_data : 8'h00;
    if (rst_n) begin
      m_ev = ((m_ev & ~clr) | set) & IMPL;
      if (wr_en && wr_sel) m_mask = wr_data & IMPL;
    end
    @(negedge clk);
    idle();
  endtask

  task automatic read_both(string tag, logic [7:0] e_ev, logic [7:0] e_mask);
    rd_sel = 0; #1 chk8(tag, rd_data, e_ev);
    rd_sel = 1; #1 chk8(tag, rd_data, e_mask);
    rd_sel = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset contents
    read_both("R1 during reset", 8'h00, 8'h00);
    rst_n = 1;
    @(negedge clk);
    read_both("R1 after reset", 8'h00, 8'h00);

    // R2: each pulse sets its own bit
    ev_txe = 1;  step("R2 txe");  read_both("R2 txe pos", 8'h10, 8'h00);
    ev_busy = 1; step("R2 busy"); read_both("R2 busy pos", 8'h14, 8'h00);
    ev_txb = 1;  step("R2 txb");  read_both("R2 txb pos", 8'h16, 8'h00);
    ev_rxb = 1;  step("R2 rxb");  read_both("R2 rxb pos", 8'h17, 8'h00);
    step("R2 sticky"); read_both("R2 sticky", 8'h17, 8'h00);

    // R6: masked flags keep irq low
    compare("R6 all masked");
    chk8("R6 irq masked", {7'd0, irq}, 8'h00);

    // R3: clear by ones, zeros leave
    wr_en = 1; wr_sel = 0; wr_data = 8'h12; step("R3 clear");
    read_both("R3 partial clear", 8'h05, 8'h00);
    wr_en = 1; wr_sel = 0; wr_data = 8'h00; step("R3 zero write");
    read_both("R3 zero write", 8'h05, 8'h00);

    // R4: set beats clear
    wr_en = 1; wr_sel = 0; wr_data = 8'h04; ev_busy = 1; step("R4 collide");
    read_both("R4 set wins", 8'h05, 8'h00);

    // R5 / R8: enable register, reserved bits
    wr_en = 1; wr_sel = 1; wr_data = 8'hFF; step("R5 mask write");
    read_both("R8 mask reserved", 8'h05, 8'h37);
    wr_en = 1; wr_sel = 1; wr_data = 8'h02; step("R5 mask write2");
    read_both("R5 mask value", 8'h05, 8'h02);
    step("R5 mask hold");
    read_both("R5 mask hold", 8'h05, 8'h02);

    // R6: irq follows enabled flags
    chk8("R6 no enabled flag", {7'd0, irq}, 8'h00);
    ev_txb = 1; step("R6 raise");
    #1 chk8("R6 irq high", {7'd0, irq}, 8'h01);
    wr_en = 1; wr_sel = 1; wr_data = 8'h03; step("R6 more enable");
    wr_en = 1; wr_sel = 0; wr_data = 8'h02; step("R6 partial clear");
    #1 chk8("R6 irq held by rxb", {7'd0, irq}, 8'h01);
    wr_en = 1; wr_sel = 0; wr_data = 8'h01; step("R6 last clear");
    #1 chk8("R6 irq low", {7'd0, irq}, 8'h00);

    // R7: multimaster conflict
    master_mode = 0; sel_n = 0; step("R7 slave select");
    rd_sel = 0; #1 chk8("R7 slave ignored", rd_data & 8'h20, 8'h00);
    master_mode = 1; sel_n = 0; step("R7 master select");
    rd_sel = 0; #1 chk8("R7 master set", rd_data & 8'h20, 8'h20);
    wr_en = 1; wr_sel = 0; wr_data = 8'h20; step("R7 clear");
    rd_sel = 0; #1 chk8("R7 cleared", rd_data & 8'h20, 8'h00);

    // R8: reserved bits of flag register
    wr_en = 1; wr_sel = 0; wr_data = 8'hFF; step("R8 clear all");
    read_both("R8 flags zero", 8'h00, 8'h03);

    // R9: read select, plus random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      rd_sel = $urandom_range(0, 1);
      master_mode = $urandom_range(0, 1);
      sel_n = ($urandom_range(0, 7) != 0);
      ev_txe = ($urandom_range(0, 5) == 0);
      ev_busy = ($urandom_range(0, 5) == 0);
      ev_txb = ($urandom_range(0, 5) == 0);
      ev_rxb = ($urandom_range(0, 5) == 0);
      wr_en = ($urandom_range(0, 2) == 0);
      wr_sel = $urandom_range(0, 1);
      wr_data = 8'($urandom);
      step("R9 random");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule